// File: doc/BRIEF.md
# Indirect Register Access Port

This block gives a processor access to one port's bank of sixteen internal registers. The bus has no address lines, only a byte-wide data path with read and write strobes. An address-less write sequence chooses the target. The first write of a pair loads a 4-bit pointer, and the second write delivers the byte to the register that the pointer names. A read returns the register under the pointer and always sends the sequencer back to expecting a pointer.

The block owns the pointer, the phase flag and control register 0. It turns each bus access into a registered one-cycle strobe with a one-hot select, which the register file outside acts on. While the reset bit of control register 0 is set, the port is held in a reset state: reads return control register 0 and writes load control register 0 directly. A second-port variant, chosen by parameter, adds a gate. The gate drops every access while the port is disabled or while the port is configured for plain I/O use.

Top module: `ipr_port_access`

## Requirements
- R1: A synchronous reset puts the pointer at 0, the phase at pointer phase, control register 0 at 0x01 (reset bit is bit 0), both strobes low, both selects zero and the read data at 0.
- R2: In pointer phase, outside the reset state, a write loads data bits 3:0 into the pointer, ignores bits 7:4 and moves to data phase.
- R3: In data phase, outside the reset state, a write to a writable register gives a one-cycle write strobe in the next cycle. The write select is one-hot at the pointer position and carries the written byte. The phase returns to pointer phase.
- R4: Outside the reset state, a read gives a one-cycle read strobe in the next cycle, with a one-hot read select at the pointer. The read data is the selected register: pointer 0 is control register 0, and pointer n (1 to 15) is byte n-1 of the bank read-data input. After the read the phase is pointer phase.
- R5: In the reset state (control register 0 bit 0 set), a read returns control register 0 whatever the pointer holds and gives no read strobe.
- R6: In the reset state, a write sets the pointer to 0 and the phase to pointer phase, loads the byte into control register 0, and gives no write strobe.
- R7: A data-phase write with pointer 0 loads control register 0. Writing bit 0 high this way enters the reset state.
- R8: Pointers 7 and 12 are read-only. A data-phase write to either gives no write strobe, but the phase still returns to pointer phase.
- R9: In the second-port variant, an access is ignored while the enable input is low or the I/O-mode input is high. The pointer, phase and control register 0 keep their values, no strobe is given, and a blocked read returns 0.
- R10: When read and write are asserted in the same cycle, the read is performed and the write is ignored.
- R11: Strobes last exactly one cycle unless a new access follows. Each select is one-hot while its strobe is high and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read request, one cycle per access |
| bus_wr | input | 1 | Write request, one cycle per access |
| bus_wdata | input | 8 | Write data byte |
| p2_enable | input | 1 | Port enable (second-port variant only) |
| p2_io_mode | input | 1 | Port in plain I/O mode (second-port variant only) |
| bank_rdata | input | 120 | Read data of registers 1 to 15, register n at byte n-1 |
| bus_rdata | output | 8 | Registered read data |
| rd_stb | output | 1 | Read strobe to the register file |
| rd_sel | output | 16 | One-hot read select |
| wr_stb | output | 1 | Write strobe to the register file |
| wr_sel | output | 16 | One-hot write select |
| wr_data | output | 8 | Write data to the register file |
| ctrl0 | output | 8 | Control register 0 |
| cur_ptr | output | 4 | Current register pointer |
| data_phase | output | 1 | High when the next write is a data write |

## Verification
The bench builds the block in its second-port variant with sixteen byte-wide registers. This makes the enable and I/O-mode gate reachable, and it puts the read-only positions at pointers 7 and 12. Each bank byte is filled with a value that encodes its own index, so a read through the wrong slot shows up as a wrong byte. The stimulus table moves the port out of the reset state, through both read-only pointers, through a combined read and write, and back into the reset state by a pointer-0 write.

// File: rtl/ipr_pkg.sv
package ipr_pkg;
  typedef enum logic {
    PH_PTR  = 1'b0,
    PH_DATA = 1'b1
  } phase_e;
endpackage

// File: rtl/ipr_gate.sv
module ipr_gate #(
  parameter bit SECOND = 1'b1
) (
  input  logic bus_rd,
  input  logic bus_wr,
  input  logic p2_enable,
  input  logic p2_io_mode,
  output logic acc_rd,
  output logic acc_wr,
  output logic blk_rd
);
  logic allow;

  generate
    if (SECOND) begin : g_second
      assign allow = p2_enable & ~p2_io_mode;
    end else begin : g_first
      logic unused_gate_in;
      assign unused_gate_in = p2_enable ^ p2_io_mode;
      assign allow = 1'b1;
    end
  endgenerate

  // read wins over a simultaneous write
  assign acc_rd = bus_rd & allow;
  assign acc_wr = bus_wr & ~bus_rd & allow;
  assign blk_rd = bus_rd & ~allow;
endmodule

// File: rtl/ipr_seq.sv
module ipr_seq
  import ipr_pkg::*;
#(
  parameter int          DW      = 8,
  parameter int          PW      = 4,
  parameter logic [7:0]  C0_RST  = 8'h01,
  parameter int          RST_BIT = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_rd,
  input  logic          acc_wr,
  input  logic [DW-1:0] wdata,
  output logic [PW-1:0] ptr,
  output phase_e        phase,
  output logic [DW-1:0] ctrl0
);
  logic in_rst;
  assign in_rst = ctrl0[RST_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr   <= '0;
      phase <= PH_PTR;
      ctrl0 <= DW'(C0_RST);
    end else if (acc_rd) begin
      phase <= PH_PTR;
    end else if (acc_wr) begin
      if (in_rst) begin
        ptr   <= '0;
        phase <= PH_PTR;
        ctrl0 <= wdata;
      end else if (phase == PH_PTR) begin
        ptr   <= wdata[PW-1:0];
        phase <= PH_DATA;
      end else begin
        phase <= PH_PTR;
        if (ptr == '0) ctrl0 <= wdata;
      end
    end
  end
endmodule

// File: rtl/ipr_decode.sv
module ipr_decode #(
  parameter int              NREG    = 16,
  parameter int              PW      = 4,
  parameter logic [NREG-1:0] RO_MASK = 16'h1080
) (
  input  logic [PW-1:0]   ptr,
  output logic [NREG-1:0] onehot,
  output logic            writable
);
  generate
    for (genvar i = 0; i < NREG; i++) begin : g_dec
      assign onehot[i] = (ptr == PW'(i));
    end
  endgenerate

  assign writable = |(onehot & ~RO_MASK);
endmodule

// File: rtl/ipr_rdmux.sv
module ipr_rdmux #(
  parameter int NREG = 16,
  parameter int DW   = 8,
  parameter int PW   = 4
) (
  input  logic [PW-1:0]          ptr,
  input  logic [DW-1:0]          ctrl0,
  input  logic [(NREG-1)*DW-1:0] bank,
  output logic [DW-1:0]          rdata
);
  logic [DW-1:0] slot [NREG];

  assign slot[0] = ctrl0;
  generate
    for (genvar i = 1; i < NREG; i++) begin : g_slot
      assign slot[i] = bank[(i-1)*DW +: DW];
    end
  endgenerate

  assign rdata = slot[ptr];
endmodule

// File: rtl/ipr_port_access.sv
module ipr_port_access
  import ipr_pkg::*;
#(
  parameter int              NREG    = 16,
  parameter int              DW      = 8,
  parameter bit              SECOND  = 1'b1,
  parameter logic [7:0]      C0_RST  = 8'h01,
  parameter int              RST_BIT = 0,
  parameter logic [NREG-1:0] RO_MASK = 16'h1080,
  localparam int             PW      = $clog2(NREG),
  localparam int             BW      = (NREG-1)*DW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_rd,
  input  logic            bus_wr,
  input  logic [DW-1:0]   bus_wdata,
  input  logic            p2_enable,
  input  logic            p2_io_mode,
  input  logic [BW-1:0]   bank_rdata,
  output logic [DW-1:0]   bus_rdata,
  output logic            rd_stb,
  output logic [NREG-1:0] rd_sel,
  output logic            wr_stb,
  output logic [NREG-1:0] wr_sel,
  output logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   ctrl0,
  output logic [PW-1:0]   cur_ptr,
  output logic            data_phase
);
  logic            acc_rd, acc_wr, blk_rd;
  phase_e          phase;
  logic [NREG-1:0] onehot;
  logic            writable;
  logic [DW-1:0]   rdata_sel;
  logic            in_rst;

  ipr_gate #(.SECOND(SECOND)) gate_i (
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .p2_enable (p2_enable),
    .p2_io_mode(p2_io_mode),
    .acc_rd    (acc_rd),
    .acc_wr    (acc_wr),
    .blk_rd    (blk_rd)
  );

  ipr_seq #(.DW(DW), .PW(PW), .C0_RST(C0_RST), .RST_BIT(RST_BIT)) seq_i (
    .clk   (clk),
    .rst   (rst),
    .acc_rd(acc_rd),
    .acc_wr(acc_wr),
    .wdata (bus_wdata),
    .ptr   (cur_ptr),
    .phase (phase),
    .ctrl0 (ctrl0)
  );

  ipr_decode #(.NREG(NREG), .PW(PW), .RO_MASK(RO_MASK)) dec_i (
    .ptr     (cur_ptr),
    .onehot  (onehot),
    .writable(writable)
  );

  ipr_rdmux #(.NREG(NREG), .DW(DW), .PW(PW)) mux_i (
    .ptr  (cur_ptr),
    .ctrl0(ctrl0),
    .bank (bank_rdata),
    .rdata(rdata_sel)
  );

  assign in_rst     = ctrl0[RST_BIT];
  assign data_phase = (phase == PH_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      rd_stb    <= 1'b0;
      rd_sel    <= '0;
      wr_stb    <= 1'b0;
      wr_sel    <= '0;
      wr_data   <= '0;
    end else begin
      rd_stb <= 1'b0;
      rd_sel <= '0;
      wr_stb <= 1'b0;
      wr_sel <= '0;
      if (acc_rd) begin
        if (in_rst) begin
          bus_rdata <= ctrl0;
        end else begin
          bus_rdata <= rdata_sel;
          rd_stb    <= 1'b1;
          rd_sel    <= onehot;
        end
      end else if (blk_rd) begin
        bus_rdata <= '0;
      end
      if (acc_wr && !in_rst && data_phase && writable) begin
        wr_stb  <= 1'b1;
        wr_sel  <= onehot;
        wr_data <= bus_wdata;
      end
    end
  end
endmodule

// File: rtl/ipr_port_access_chk.sv
module ipr_port_access_chk #(
  parameter int              NREG    = 16,
  parameter int              DW      = 8,
  parameter bit              SECOND  = 1'b1,
  parameter int              RST_BIT = 0,
  parameter logic [NREG-1:0] RO_MASK = 16'h1080,
  localparam int             PW      = $clog2(NREG)
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_rd,
  input logic            bus_wr,
  input logic [DW-1:0]   bus_wdata,
  input logic            p2_enable,
  input logic            p2_io_mode,
  input logic [DW-1:0]   bus_rdata,
  input logic            rd_stb,
  input logic [NREG-1:0] rd_sel,
  input logic            wr_stb,
  input logic [NREG-1:0] wr_sel,
  input logic [DW-1:0]   wr_data,
  input logic [DW-1:0]   ctrl0,
  input logic [PW-1:0]   cur_ptr,
  input logic            data_phase
);
  logic open_p;
  assign open_p = !SECOND || (p2_enable && !p2_io_mode);

  logic wr_only;
  assign wr_only = bus_wr && !bus_rd && open_p;

  // R2
  ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_only && !data_phase && !ctrl0[RST_BIT]) |=>
      (data_phase && cur_ptr == $past(bus_wdata[PW-1:0])));

  // R3
  data_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_only && data_phase && !ctrl0[RST_BIT] && !RO_MASK[cur_ptr]) |=>
      (wr_stb && wr_data == $past(bus_wdata) && !data_phase));

  // R4
  read_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && open_p) |=> !data_phase);

  // R5
  rst_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && open_p && ctrl0[RST_BIT]) |=> (bus_rdata == $past(ctrl0) && !rd_stb));

  // R6
  rst_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_only && ctrl0[RST_BIT]) |=>
      (cur_ptr == '0 && !data_phase && ctrl0 == $past(bus_wdata) && !wr_stb));

  // R8
  ro_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_only && data_phase && !ctrl0[RST_BIT] && RO_MASK[cur_ptr]) |=> (!wr_stb && !data_phase));

  // R9
  gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((bus_rd || bus_wr) && !open_p) |=>
      ($stable(cur_ptr) && $stable(data_phase) && $stable(ctrl0) && !rd_stb && !wr_stb));

  // R10
  rd_priority_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_wr) |=> !wr_stb);

  // R11
  wr_sel_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb ? ($countones(wr_sel) == 1) : (wr_sel == '0));

  // R11
  rd_sel_chk: assert property (@(posedge clk) disable iff (rst)
    rd_stb ? ($countones(rd_sel) == 1) : (rd_sel == '0));
endmodule

bind ipr_port_access ipr_port_access_chk #(
  .NREG(NREG), .DW(DW), .SECOND(SECOND), .RST_BIT(RST_BIT), .RO_MASK(RO_MASK)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .p2_enable (p2_enable),
  .p2_io_mode(p2_io_mode),
  .bus_rdata (bus_rdata),
  .rd_stb    (rd_stb),
  .rd_sel    (rd_sel),
  .wr_stb    (wr_stb),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .ctrl0     (ctrl0),
  .cur_ptr   (cur_ptr),
  .data_phase(data_phase)
);

// File: tb/ipr_port_access_tb_top.sv
`timescale 1ns/100ps
module ipr_port_access_tb_top;
  localparam int NREG = 16;
  localparam int DW   = 8;
  localparam int NV   = 18;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]     bus_wdata = '0;
  logic           p2_enable = 1'b1, p2_io_mode = 1'b0;
  logic [119:0]   bank_rdata;
  logic [7:0]     bus_rdata, wr_data, ctrl0;
  logic           rd_stb, wr_stb, data_phase;
  logic [15:0]    rd_sel, wr_sel;
  logic [3:0]     cur_ptr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ipr_port_access #(.NREG(NREG), .DW(DW), .SECOND(1'b1)) dut_i (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .p2_enable(p2_enable), .p2_io_mode(p2_io_mode), .bank_rdata(bank_rdata),
    .bus_rdata(bus_rdata), .rd_stb(rd_stb), .rd_sel(rd_sel), .wr_stb(wr_stb),
    .wr_sel(wr_sel), .wr_data(wr_data), .ctrl0(ctrl0), .cur_ptr(cur_ptr),
    .data_phase(data_phase)
  );

  // fields: req[36:33] op[32:31] (0 idle,1 wr,2 rd,3 both) data[30:23]
  //         ptr[22:19] phase[18] ctrl0[17:10] wstb[9] rstb[8] rdata[7:0]
  localparam logic [36:0] VEC [NV] = '{
    {4'd5,  2'd2, 8'h00, 4'h0, 1'b0, 8'h01, 1'b0, 1'b0, 8'h01}, // R5 read in reset state
    {4'd6,  2'd1, 8'h5A, 4'h0, 1'b0, 8'h5A, 1'b0, 1'b0, 8'h01}, // R6 write in reset state
    {4'd2,  2'd1, 8'h07, 4'h7, 1'b1, 8'h5A, 1'b0, 1'b0, 8'h01}, // R2
    {4'd8,  2'd1, 8'h33, 4'h7, 1'b0, 8'h5A, 1'b0, 1'b0, 8'h01}, // R8 pointer 7
    {4'd2,  2'd1, 8'h03, 4'h3, 1'b1, 8'h5A, 1'b0, 1'b0, 8'h01}, // R2
    {4'd3,  2'd1, 8'hC4, 4'h3, 1'b0, 8'h5A, 1'b1, 1'b0, 8'h01}, // R3
    {4'd2,  2'd1, 8'h15, 4'h5, 1'b1, 8'h5A, 1'b0, 1'b0, 8'h01}, // R2 upper bits ignored
    {4'd4,  2'd2, 8'h00, 4'h5, 1'b0, 8'h5A, 1'b0, 1'b1, 8'h35}, // R4
    {4'd2,  2'd1, 8'hFC, 4'hC, 1'b1, 8'h5A, 1'b0, 1'b0, 8'h35}, // R2
    {4'd8,  2'd1, 8'h99, 4'hC, 1'b0, 8'h5A, 1'b0, 1'b0, 8'h35}, // R8 pointer 12
    {4'd2,  2'd1, 8'h00, 4'h0, 1'b1, 8'h5A, 1'b0, 1'b0, 8'h35}, // R2
    {4'd7,  2'd1, 8'h5E, 4'h0, 1'b0, 8'h5E, 1'b1, 1'b0, 8'h35}, // R7
    {4'd2,  2'd1, 8'h0F, 4'hF, 1'b1, 8'h5E, 1'b0, 1'b0, 8'h35}, // R2
    {4'd10, 2'd3, 8'h77, 4'hF, 1'b0, 8'h5E, 1'b0, 1'b1, 8'h3F}, // R10
    {4'd11, 2'd0, 8'h00, 4'hF, 1'b0, 8'h5E, 1'b0, 1'b0, 8'h3F}, // R11 strobe ends
    {4'd2,  2'd1, 8'h00, 4'h0, 1'b1, 8'h5E, 1'b0, 1'b0, 8'h3F}, // R2
    {4'd7,  2'd1, 8'h81, 4'h0, 1'b0, 8'h81, 1'b1, 1'b0, 8'h3F}, // R7 enters reset state
    {4'd6,  2'd1, 8'h0A, 4'h0, 1'b0, 8'h0A, 1'b0, 1'b0, 8'h3F}  // R6
  };

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // drive at negedge, one edge, sample at the following negedge
  task automatic access(input logic rd, input logic wr, input logic [7:0] d);
    bus_rd = rd; bus_wr = wr; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  initial begin
    for (int i = 1; i < NREG; i++) bank_rdata[(i-1)*8 +: 8] = 8'h30 + 8'(i);
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R1 state after power-on reset
    chk("R1", "ptr",   32'(cur_ptr), 32'h0);
    chk("R1", "phase", 32'(data_phase), 32'h0);
    chk("R1", "ctrl0", 32'(ctrl0), 32'h01);
    chk("R1", "strobes", 32'({rd_stb, wr_stb}), 32'h0);
    chk("R1", "rdata", 32'(bus_rdata), 32'h0);

    for (int v = 0; v < NV; v++) begin
      logic [36:0] e;
      string r;
      e = VEC[v];
      r = $sformatf("R%0d", e[36:33]);
      access(e[32], e[31], e[30:23]);
      chk(r, "ptr",   32'(cur_ptr), 32'(e[22:19]));
      chk(r, "phase", 32'(data_phase), 32'(e[18]));
      chk(r, "ctrl0", 32'(ctrl0), 32'(e[17:10]));
      chk(r, "wr_stb", 32'(wr_stb), 32'(e[9]));
      chk(r, "rd_stb", 32'(rd_stb), 32'(e[8]));
      chk(r, "rdata", 32'(bus_rdata), 32'(e[7:0]));
      if (e[9]) begin
        // R3 / R11 select and data of a write strobe
        chk(r, "wr_sel",  32'(wr_sel), 32'(16'h1 << e[22:19]));
        chk(r, "wr_data", 32'(wr_data), 32'(e[30:23]));
      end else chk("R11", "wr_sel idle", 32'(wr_sel), 32'h0);
      if (e[8]) chk(r, "rd_sel", 32'(rd_sel), 32'(16'h1 << e[22:19]));
      else      chk("R11", "rd_sel idle", 32'(rd_sel), 32'h0);
    end

    // R9 disabled port ignores write and read
    p2_enable = 1'b0;
    access(1'b0, 1'b1, 8'h06);
    chk("R9", "ptr disabled", 32'(cur_ptr), 32'h0);
    chk("R9", "phase disabled", 32'(data_phase), 32'h0);
    chk("R9", "ctrl0 disabled", 32'(ctrl0), 32'h0A);
    access(1'b1, 1'b0, 8'h00);
    chk("R9", "rdata disabled", 32'(bus_rdata), 32'h0);
    chk("R9", "rd_stb disabled", 32'(rd_stb), 32'h0);
    // R9 I/O mode ignores write
    p2_enable = 1'b1; p2_io_mode = 1'b1;
    access(1'b0, 1'b1, 8'h06);
    chk("R9", "ptr io mode", 32'(cur_ptr), 32'h0);
    chk("R9", "phase io mode", 32'(data_phase), 32'h0);
    p2_io_mode = 1'b0;
    access(1'b0, 1'b1, 8'h06);
    chk("R2", "ptr reenabled", 32'(cur_ptr), 32'h6);
    access(1'b1, 1'b0, 8'h00);
    chk("R4", "rdata slot 6", 32'(bus_rdata), 32'h36);
    chk("R4", "phase after read", 32'(data_phase), 32'h0);

    // R1 reset in the middle of a sequence
    access(1'b0, 1'b1, 8'h09);
    chk("R2", "ptr before reset", 32'(cur_ptr), 32'h9);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    chk("R1", "ptr after reset", 32'(cur_ptr), 32'h0);
    chk("R1", "phase after reset", 32'(data_phase), 32'h0);
    chk("R1", "ctrl0 after reset", 32'(ctrl0), 32'h01);
    chk("R1", "rdata after reset", 32'(bus_rdata), 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule